// File: doc/BRIEF.md
# Parallel Panel Timing Generator

This block produces the raster timing for a parallel RGB panel. It drives horizontal sync, vertical sync, a data-enable strobe and the pixel column and row inside the visible area. Software sets it up through a plain register write/read port. Pixel fetch, colour handling and memory traffic belong to other blocks.

Each line is a sequence of four horizontal phases: sync pulse, back porch, visible pixels, front porch. Each frame runs the same four phases, counted in lines. Every length field holds its count minus one. Pixel steps come from a clock enable. When the divide-select bit is clear, the enable is high on every clock. When the bit is set, the enable is high once per divisor-field-plus-one clocks.

The divider settings and the output-enable bit go through shadow registers. While the generator runs, they take effect only when a new frame starts. The run bit acts at once. A frame interrupt can fire on entry to any vertical phase. Its pending flag is cleared by writing a one, and a status register shows live whether the generator is inside the vsync pulse.

Top module: `panel_tmg_top`

## Requirements
- R1: After reset the generator is stopped. hsync, vsync, de, irq, pixX and pixY are all 0, and the status register reads 0.
- R2: While running, a line lasts (hsync field+1)+(hback field+1)+(width field+1)+(hfront field+1) pixel steps, in the order sync, back porch, active, front porch. hsync is asserted during the sync steps.
- R3: A frame is made of lines in the order vertical sync, back porch, active, front porch. Each phase lasts its line-count field plus one, and vsync is asserted during the vertical sync lines.
- R4: de is asserted only when the horizontal and vertical phases are both active and the effective output enable is 1. pixX and pixY give the offset inside the active phase of their axis and read 0 outside it.
- R5: With the effective divide-select bit (CTRL bit 2) clear, the timing advances one step per clock. With it set, the timing advances one step per divisor field (CTRL bits 15:8) plus one clocks.
- R6: While running, CTRL bits 1, 2 and 15:8 take effect only at the step that enters a new frame's vsync. While stopped, they take effect on the following clock.
- R7: The run bit (CTRL bit 0) acts at once. Clearing it returns both axes to the first sync step and makes the outputs inactive. Setting it starts at the first sync step on the next clock.
- R8: Polarity register bits 0, 1 and 2 invert hsync, vsync and de independently, and take effect at once.
- R9: The interrupt configuration register holds global enable (bit 0), frame-event enable (bit 1) and a trigger select (bits 3:2). The trigger values are 0 = vsync entry, 1 = vertical back porch entry, 2 = vertical active entry and 3 = vertical front porch entry. The pending flag sets at the selected entry when the frame-event enable is 1, and irq is the pending flag AND the global enable.
- R10: Writing 1 to bit 0 of the pending register (address 6) clears the flag. Writing 0 has no effect, and a new event in the same cycle keeps the flag set.
- R11: Bit 0 of the status register (address 7) reads 1 exactly while the generator is inside the vertical sync lines, regardless of polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address (0 ctrl, 1 horizontal, 2 vertical, 3 size, 4 polarity, 5 irq config, 6 pending, 7 status) |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data, combinational |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pixX | output | 11 | Column inside the active area |
| pixY | output | 11 | Row inside the active area |
| irq | output | 1 | Frame interrupt |

## Verification
Some rules are checked by the in-line properties on every clock. A counter moves only on a pixel step or a stop. A stop sends both axes home. Shadowed fields stay constant between frame starts. de never overlaps a sync pulse. Consecutive steps are spaced when the divisor exceeds one. Pending follows its set and clear rules.

Other behaviour can only be shown by the bench's scenarios, which compare every output arithmetically against a step count. These cover the exact phase lengths and their order, the pixel coordinates, the deferral of divider and enable changes to the frame boundary, each interrupt trigger point, and the immediate effect of polarity and run.

// File: rtl/panel_tmg_pkg.sv
package panel_tmg_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam logic [2:0] A_CTRL    = 3'd0;
  localparam logic [2:0] A_HTIM    = 3'd1;
  localparam logic [2:0] A_VTIM    = 3'd2;
  localparam logic [2:0] A_SIZE    = 3'd3;
  localparam logic [2:0] A_POL     = 3'd4;
  localparam logic [2:0] A_IRQCFG  = 3'd5;
  localparam logic [2:0] A_IRQPEND = 3'd6;
  localparam logic [2:0] A_STAT    = 3'd7;

  // control -> datapath strobes
  typedef struct packed {
    logic run;
    logic outEn;
    logic divSel;
  } tmgCtl_t;

  // datapath -> control events
  typedef struct packed {
    logic       frameWrap;
    logic       inVsync;
    logic [3:0] vEnter;
  } tmgEvt_t;
endpackage

// File: rtl/panel_tmg_axis.sv
module panel_tmg_axis
  import panel_tmg_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] syncM1,
  input  logic [CW-1:0] backM1,
  input  logic [CW-1:0] actM1,
  input  logic [CW-1:0] frontM1,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          lastUnit,
  output logic [3:0]    enterStb
);
  timeunit 1ns; timeprecision 1ps;

  logic [CW-1:0] limit;
  logic          atEnd;
  phase_e        nextPhase;

  always_comb begin
    case (phase)
      PH_SYNC:  limit = syncM1;
      PH_BACK:  limit = backM1;
      PH_ACT:   limit = actM1;
      default:  limit = frontM1;
    endcase
  end

  assign atEnd     = (cnt == limit);
  assign nextPhase = phase_e'(phase + 2'd1);
  assign lastUnit  = step && atEnd && (phase == PH_FRONT);

  always_comb begin
    enterStb = '0;
    if (step && atEnd) enterStb[nextPhase] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (clr) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (atEnd) begin
        cnt   <= '0;
        phase <= nextPhase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7
  clear_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (phase == PH_SYNC && cnt == '0));
  // R2
  hold_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !step) |=> ($stable(cnt) && $stable(phase)));
endmodule

// File: rtl/panel_tmg_ctrl.sv
module panel_tmg_ctrl
  import panel_tmg_pkg::*;
#(
  parameter int PW = 8,
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [31:0]   wrData,
  input  logic [2:0]    rdAddr,
  output logic [31:0]   rdData,
  input  tmgEvt_t       evt,
  output tmgCtl_t       ctl,
  output logic [DW-1:0] divM1,
  output logic [PW-1:0] hSyncM1,
  output logic [PW-1:0] hBackM1,
  output logic [PW-1:0] hFrontM1,
  output logic [PW-1:0] vSyncM1,
  output logic [PW-1:0] vBackM1,
  output logic [PW-1:0] vFrontM1,
  output logic [HW-1:0] hActM1,
  output logic [VW-1:0] vActM1,
  output logic [2:0]    pol,
  output logic          irq
);
  timeunit 1ns; timeprecision 1ps;

  logic          runReg, outEnReg, divSelReg;
  logic [DW-1:0] divM1Reg;
  logic          outEnSh, divSelSh;
  logic [DW-1:0] divM1Sh;
  logic          irqGlob, irqFrame, pend;
  logic [1:0]    irqSel;
  logic          takeSh, evtHit, clrPend;
  logic          unusedWr;

  assign unusedWr = ^wrData;
  assign takeSh   = !runReg || evt.frameWrap;
  assign evtHit   = evt.vEnter[irqSel] && irqFrame;
  assign clrPend  = wrEn && (wrAddr == A_IRQPEND) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg <= 1'b0; outEnReg <= 1'b0; divSelReg <= 1'b0; divM1Reg <= '0;
      hSyncM1 <= '0; hBackM1 <= '0; hFrontM1 <= '0; hActM1 <= '0;
      vSyncM1 <= '0; vBackM1 <= '0; vFrontM1 <= '0; vActM1 <= '0;
      pol <= '0; irqGlob <= 1'b0; irqFrame <= 1'b0; irqSel <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL: begin
          runReg    <= wrData[0];
          outEnReg  <= wrData[1];
          divSelReg <= wrData[2];
          divM1Reg  <= wrData[8 +: DW];
        end
        A_HTIM: begin
          hSyncM1  <= wrData[0 +: PW];
          hBackM1  <= wrData[8 +: PW];
          hFrontM1 <= wrData[16 +: PW];
        end
        A_VTIM: begin
          vSyncM1  <= wrData[0 +: PW];
          vBackM1  <= wrData[8 +: PW];
          vFrontM1 <= wrData[16 +: PW];
        end
        A_SIZE: begin
          hActM1 <= wrData[0 +: HW];
          vActM1 <= wrData[16 +: VW];
        end
        A_POL: pol <= wrData[2:0];
        A_IRQCFG: begin
          irqGlob  <= wrData[0];
          irqFrame <= wrData[1];
          irqSel   <= wrData[3:2];
        end
        default: ;
      endcase
    end
  end

  // frame-synchronised shadows: follow the register while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEnSh  <= 1'b0;
      divSelSh <= 1'b0;
      divM1Sh  <= '0;
    end else if (takeSh) begin
      outEnSh  <= outEnReg;
      divSelSh <= divSelReg;
      divM1Sh  <= divM1Reg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pend <= 1'b0;
    else if (evtHit)  pend <= 1'b1;
    else if (clrPend) pend <= 1'b0;
  end

  assign irq        = pend && irqGlob;
  assign ctl.run    = runReg;
  assign ctl.outEn  = outEnSh;
  assign ctl.divSel = divSelSh;
  assign divM1      = divM1Sh;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL: begin
        rdData[0] = runReg; rdData[1] = outEnReg; rdData[2] = divSelReg;
        rdData[8 +: DW] = divM1Reg;
      end
      A_HTIM: begin
        rdData[0 +: PW] = hSyncM1; rdData[8 +: PW] = hBackM1; rdData[16 +: PW] = hFrontM1;
      end
      A_VTIM: begin
        rdData[0 +: PW] = vSyncM1; rdData[8 +: PW] = vBackM1; rdData[16 +: PW] = vFrontM1;
      end
      A_SIZE: begin
        rdData[0 +: HW] = hActM1; rdData[16 +: VW] = vActM1;
      end
      A_POL:     rdData[2:0] = pol;
      A_IRQCFG:  rdData[3:0] = {irqSel, irqFrame, irqGlob};
      A_IRQPEND: rdData[0] = pend;
      default:   rdData[1:0] = {runReg, evt.inVsync};
    endcase
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runReg && !evt.frameWrap) |=> ($stable(outEnSh) && $stable(divSelSh) && $stable(divM1Sh)));
  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.vEnter[irqSel] && irqFrame) |=> pend);
  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrPend && !(evt.vEnter[irqSel] && irqFrame)) |=> !pend);
endmodule

// File: rtl/panel_tmg_core.sv
module panel_tmg_core
  import panel_tmg_pkg::*;
#(
  parameter int PW = 8,
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmgCtl_t       ctl,
  input  logic [DW-1:0] divM1,
  input  logic [PW-1:0] hSyncM1,
  input  logic [PW-1:0] hBackM1,
  input  logic [PW-1:0] hFrontM1,
  input  logic [PW-1:0] vSyncM1,
  input  logic [PW-1:0] vBackM1,
  input  logic [PW-1:0] vFrontM1,
  input  logic [HW-1:0] hActM1,
  input  logic [VW-1:0] vActM1,
  input  logic [2:0]    pol,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] pixX,
  output logic [VW-1:0] pixY,
  output tmgEvt_t       evt
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CWH = (HW > PW) ? HW : PW;
  localparam int CWV = (VW > PW) ? VW : PW;

  logic [DW-1:0]  divCnt;
  logic           tick;
  phase_e         hPhase, vPhase;
  logic [CWH-1:0] hCnt;
  logic [CWV-1:0] vCnt;
  logic           hLast, vLast;
  logic [3:0]     hEnter, vEnter;
  logic           hsRaw, vsRaw, deRaw;
  logic           unusedEnter;

  assign tick = ctl.run && (!ctl.divSel || (divCnt == divM1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      divCnt <= '0;
    else if (!ctl.run || !ctl.divSel) divCnt <= '0;
    else if (tick)                  divCnt <= '0;
    else                            divCnt <= divCnt + 1'b1;
  end

  panel_tmg_axis #(.CW(CWH)) uHor (
    .clk(clk), .rstN(rstN), .clr(!ctl.run), .step(tick),
    .syncM1(CWH'(hSyncM1)), .backM1(CWH'(hBackM1)),
    .actM1(CWH'(hActM1)), .frontM1(CWH'(hFrontM1)),
    .phase(hPhase), .cnt(hCnt), .lastUnit(hLast), .enterStb(hEnter)
  );

  panel_tmg_axis #(.CW(CWV)) uVer (
    .clk(clk), .rstN(rstN), .clr(!ctl.run), .step(tick && hLast),
    .syncM1(CWV'(vSyncM1)), .backM1(CWV'(vBackM1)),
    .actM1(CWV'(vActM1)), .frontM1(CWV'(vFrontM1)),
    .phase(vPhase), .cnt(vCnt), .lastUnit(vLast), .enterStb(vEnter)
  );

  assign unusedEnter = ^hEnter;

  assign hsRaw = ctl.run && (hPhase == PH_SYNC);
  assign vsRaw = ctl.run && (vPhase == PH_SYNC);
  assign deRaw = ctl.run && ctl.outEn && (hPhase == PH_ACT) && (vPhase == PH_ACT);

  assign hsync = hsRaw ^ pol[0];
  assign vsync = vsRaw ^ pol[1];
  assign de    = deRaw ^ pol[2];
  assign pixX  = (ctl.run && hPhase == PH_ACT) ? hCnt[HW-1:0] : '0;
  assign pixY  = (ctl.run && vPhase == PH_ACT) ? vCnt[VW-1:0] : '0;

  assign evt.frameWrap = vLast;
  assign evt.inVsync   = vsRaw;
  assign evt.vEnter    = vEnter;

  // R5
  div_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ctl.divSel && divM1 != '0) |=> (!tick || !ctl.divSel || divM1 == '0));
  // R4
  de_no_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (de != pol[2]) |-> ((hsync == pol[0]) && (vsync == pol[1])));
endmodule

// File: rtl/panel_tmg_top.sv
module panel_tmg_top
  import panel_tmg_pkg::*;
#(
  parameter int PW = 8,
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [31:0]   wrData,
  input  logic [2:0]    rdAddr,
  output logic [31:0]   rdData,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] pixX,
  output logic [VW-1:0] pixY,
  output logic          irq
);
  timeunit 1ns; timeprecision 1ps;

  tmgCtl_t       ctl;
  tmgEvt_t       evt;
  logic [DW-1:0] divM1;
  logic [PW-1:0] hSyncM1, hBackM1, hFrontM1, vSyncM1, vBackM1, vFrontM1;
  logic [HW-1:0] hActM1;
  logic [VW-1:0] vActM1;
  logic [2:0]    pol;

  panel_tmg_ctrl #(.PW(PW), .HW(HW), .VW(VW), .DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evt(evt), .ctl(ctl), .divM1(divM1),
    .hSyncM1(hSyncM1), .hBackM1(hBackM1), .hFrontM1(hFrontM1),
    .vSyncM1(vSyncM1), .vBackM1(vBackM1), .vFrontM1(vFrontM1),
    .hActM1(hActM1), .vActM1(vActM1), .pol(pol), .irq(irq)
  );

  panel_tmg_core #(.PW(PW), .HW(HW), .VW(VW), .DW(DW)) uCore (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divM1(divM1),
    .hSyncM1(hSyncM1), .hBackM1(hBackM1), .hFrontM1(hFrontM1),
    .vSyncM1(vSyncM1), .vBackM1(vBackM1), .vFrontM1(vFrontM1),
    .hActM1(hActM1), .vActM1(vActM1), .pol(pol),
    .hsync(hsync), .vsync(vsync), .de(de), .pixX(pixX), .pixY(pixY), .evt(evt)
  );
endmodule

// File: tb/sim_panel_tmg_top.sv
module sim_panel_tmg_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int HS = 2, HB = 3, HA = 4, HF = 1;
  localparam int VS = 1, VB = 2, VA = 3, VF = 1;
  localparam int L = HS + HB + HA + HF;
  localparam int F = VS + VB + VA + VF;
  localparam int T = L * F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = 3'd7;
  logic [31:0] rdData;
  logic        hsync, vsync, de, irq;
  logic [10:0] pixX, pixY;

  panel_tmg_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .hsync(hsync), .vsync(vsync), .de(de),
    .pixX(pixX), .pixY(pixY), .irq(irq)
  );

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string tag = "R1";

  // bench model of the programmed state
  bit     mRun, mOutReg, mDivSelReg, mOutEff, mGlob, mFrame, mPend;
  int     mDivM1Reg, mDEff, mSel, t, dcnt, tn;
  bit [2:0] mPol;
  bit     mTk, mWrap, mEvt;

  function automatic void chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endfunction

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mOutReg = 0; mDivSelReg = 0; mOutEff = 0; mGlob = 0; mFrame = 0;
      mPend = 0; mDivM1Reg = 0; mDEff = 1; mSel = 0; t = 0; dcnt = 0; mPol = 0;
    end else begin
      mWrap = 0; mEvt = 0;
      if (!mRun) begin
        t = 0; dcnt = 0;
      end else begin
        mTk = (mDEff == 1) || (dcnt == mDEff - 1);
        if (mTk) begin
          tn = t + 1;
          if (tn == T) begin tn = 0; mWrap = 1; end
          mEvt = (mSel == 0 && mWrap) || (mSel == 1 && tn == VS * L) ||
                 (mSel == 2 && tn == (VS + VB) * L) || (mSel == 3 && tn == (VS + VB + VA) * L);
          t = tn; dcnt = 0;
        end else dcnt++;
      end
      if (!mRun || mWrap) begin
        mOutEff = mOutReg;
        mDEff = mDivSelReg ? mDivM1Reg + 1 : 1;
      end
      if (wrEn && wrAddr == 3'd6 && wrData[0]) mPend = 0;
      if (mEvt && mFrame) mPend = 1;
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mRun = wrData[0]; mOutReg = wrData[1]; mDivSelReg = wrData[2]; mDivM1Reg = int'(wrData[15:8]); end
          3'd4: mPol = wrData[2:0];
          3'd5: begin mGlob = wrData[0]; mFrame = wrData[1]; mSel = int'(wrData[3:2]); end
          default: ;
        endcase
      end
    end
  end

  // continuous comparison, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      int x, y, ex, ey;
      bit hr, vr, ha, va, dr;
      x = t % L; y = t / L;
      ha = (x >= HS + HB) && (x < HS + HB + HA);
      va = (y >= VS + VB) && (y < VS + VB + VA);
      hr = mRun && (x < HS);
      vr = mRun && (y < VS);
      dr = mRun && mOutEff && ha && va;
      ex = (mRun && ha) ? x - HS - HB : 0;
      ey = (mRun && va) ? y - VS - VB : 0;
      chk({tag, " R2 hsync"}, int'(hsync), int'(hr ^ mPol[0]));
      chk({tag, " R3 vsync"}, int'(vsync), int'(vr ^ mPol[1]));
      chk({tag, " R4 de"}, int'(de), int'(dr ^ mPol[2]));
      chk({tag, " R4 pixX"}, int'(pixX), ex);
      chk({tag, " R4 pixY"}, int'(pixY), ey);
      chk({tag, " R9 irq"}, int'(irq), int'(mPend && mGlob));
      if (rdAddr == 3'd7) chk({tag, " R11 status"}, int'(rdData[0]), int'(vr));
      if (rdAddr == 3'd6) chk({tag, " R10 pending"}, int'(rdData[0]), int'(mPend));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setRd(input logic [2:0] a);
    @(negedge clk); rdAddr = a;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      report();
    end
  end

  initial begin
    idle(3);
    #1;
    // R1 reset state
    chk("R1 hsync", int'(hsync), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 de", int'(de), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 status", int'(rdData), 0);
    @(negedge clk); rstN = 1'b1;
    wr(3'd1, (HS - 1) | ((HB - 1) << 8) | ((HF - 1) << 16));
    wr(3'd2, (VS - 1) | ((VB - 1) << 8) | ((VF - 1) << 16));
    wr(3'd3, (HA - 1) | ((VA - 1) << 16));
    wr(3'd5, 32'h3);
    wr(3'd0, 32'h2);
    idle(3);
    tag = "R2"; wr(3'd0, 32'h3);
    idle(2 * T);
    tag = "R10"; setRd(3'd6);
    idle(T);
    wr(3'd6, 32'h0); idle(3);
    wr(3'd6, 32'h1); idle(3);
    setRd(3'd7);
    tag = "R9";
    for (int s = 1; s < 4; s++) begin
      wr(3'd5, 32'h3 | (s << 2));
      idle(T + 2);
      wr(3'd6, 32'h1);
    end
    wr(3'd5, 32'h1); idle(T + 2);
    setRd(3'd6);
    wr(3'd5, 32'h2); idle(T + 2);
    wr(3'd6, 32'h1);
    setRd(3'd7);
    wr(3'd5, 32'h3);
    tag = "R5";
    wr(3'd0, 32'h3 | 32'h4 | (2 << 8));
    idle(3 * 3 * T + 7);
    tag = "R6";
    wr(3'd0, 32'h1 | 32'h4 | (2 << 8));
    idle(2 * 3 * T);
    wr(3'd0, 32'h3 | 32'h4 | (1 << 8));
    idle(2 * 2 * T + 3);
    tag = "R8";
    wr(3'd4, 32'h7); idle(2 * T);
    wr(3'd4, 32'h2); idle(T);
    wr(3'd4, 32'h0);
    tag = "R7";
    wr(3'd0, 32'h0); idle(20);
    wr(3'd0, 32'h2); idle(3);
    wr(3'd0, 32'h3); idle(T + 5);
    report();
  end
endmodule